// File: doc/BRIEF.md
# Write Protection Command Detector

This block sits between the write front end of a byte-alterable nonvolatile memory and its page buffer. Every completed byte load (address and data) is presented to it for one cycle, and it answers in the same cycle whether that load may reach the page buffer. It holds a protection flag that stands for a nonvolatile bit. Its reset value models the factory state, which is unprotected.

While protection is off, every load goes through. The command matcher still watches the stream so that an arming sequence can be recognised. Two command sequences share the same first two writes: 0xAA to address 0x5555, then 0x55 to address 0x2AAA. The third write decides which sequence is running:
- 0xA0 to 0x5555 turns protection on and opens one page window.
- 0x80 to 0x5555 continues the disable sequence, which ends with 0xAA@0x5555, 0x55@0x2AAA and 0x20@0x5555.

The window closes when the array reports that programming is done. Protection is cleared only when the programming that follows a completed disable sequence finishes. A wrong step, or too long a pause between steps, sends the matcher back to idle.

Top module: `wp_cmd_detect`

## Requirements
- R1: After reset, `prot_on` equals parameter INIT_PROT (default 0), and with protection off `ld_pass` is 1 for any strobed load; `ld_pass` is 0 whenever `ld_stb` is 0.
- R2: While `prot_on` is 0, every strobed load gives `ld_pass`=1, command writes included.
- R3: The writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 (data on `ld_data`, address on `ld_addr`, each on its own strobe) set `prot_on` to 1 in the cycle after the third write and open a page window. This holds whether protection was off or on before.
- R4: While `prot_on` is 1 and no window is open, every strobed load, command writes included, gives `ld_pass`=0.
- R5: In an open window, the first PAGE_BYTES loads give `ld_pass`=1 and any further load gives 0.
- R6: A `prog_done` pulse while a window is open closes it; `prot_on` stays 1, and the next load is blocked.
- R7: The writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 leave `prot_on` unchanged at first. `prot_on` falls to 0 in the cycle after the next `prog_done` pulse.
- R8: A write that does not match the expected step returns the matcher to idle. If that write is itself 0xAA@0x5555, it counts as a new first step.
- R9: If GAP_CYC cycles in a row pass with no load while a sequence is part way through, the matcher returns to idle. A load after GAP_CYC-1 empty cycles still continues the sequence.
- R10: A load or command completion in the same cycle as `prog_done` is judged by the state before that cycle's edge. A window load in that cycle passes. A disable sequence completed in that cycle waits for a later `prog_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the modelled nonvolatile state |
| ld_stb | input | 1 | One-cycle strobe for a completed byte load |
| ld_addr | input | ADDR_W | Address of the load |
| ld_data | input | DATA_W | Data of the load |
| prog_done | input | 1 | Pulse when internal programming finishes |
| ld_pass | output | 1 | The strobed load may enter the page buffer |
| prot_on | output | 1 | Protection flag |

## Verification
Two events can meet in one edge: a byte load and the `prog_done` pulse that ends a programming cycle.

The bench provokes this in two places. In the first, it drives a data load in the same cycle that `prog_done` closes an armed window. That load must pass, and the load after it must be blocked. In the second, the final 0x20@0x5555 disable write lands on the same cycle as `prog_done`. `prot_on` must stay high through that edge and fall only after a later `prog_done` pulse.

// File: rtl/wp_cmd_detect.sv
module wp_cmd_detect #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 128,
  parameter int GAP_CYC = 20000,
  parameter bit INIT_PROT = 1'b0,
  parameter logic [ADDR_W-1:0] CMD_A = 15'h5555,
  parameter logic [ADDR_W-1:0] CMD_B = 15'h2AAA,
  parameter logic [DATA_W-1:0] K_UNLK1 = 8'hAA,
  parameter logic [DATA_W-1:0] K_UNLK2 = 8'h55,
  parameter logic [DATA_W-1:0] K_ARM = 8'hA0,
  parameter logic [DATA_W-1:0] K_ERASE = 8'h80,
  parameter logic [DATA_W-1:0] K_OFF = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              prog_done,
  output logic              ld_pass,
  output logic              prot_on
);
  localparam int CW = $clog2(PAGE_BYTES + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(PAGE_BYTES);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  typedef enum logic [2:0] {
    IDLE, S1, S2, D3, D4, D5, OPEN
  } st_t;

  st_t st, st_nx;
  logic prot_q, pend_off;
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;

  wire on_a     = ld_addr == CMD_A;
  wire hit1     = on_a && ld_data == K_UNLK1;
  wire hit2     = ld_addr == CMD_B && ld_data == K_UNLK2;
  wire hit_arm  = on_a && ld_data == K_ARM;
  wire hit_er   = on_a && ld_data == K_ERASE;
  wire hit_off  = on_a && ld_data == K_OFF;
  wire mid_seq  = st != IDLE && st != OPEN;
  wire win_room = st == OPEN && cnt < CNT_MAX;
  wire arm_now  = ld_stb && st == S2 && hit_arm;
  wire off_now  = ld_stb && st == D5 && hit_off;
  wire close_w  = prog_done && st == OPEN;
  wire timeout  = !ld_stb && mid_seq && gap == GAP_LAST;

  assign ld_pass = ld_stb && (!prot_q || win_room);
  assign prot_on = prot_q;

  always_comb begin
    st_nx = st;
    unique case (st)
      IDLE:    st_nx = hit1 ? S1 : IDLE;
      S1:      st_nx = hit2 ? S2 : (hit1 ? S1 : IDLE);
      S2:      st_nx = hit_arm ? OPEN : hit_er ? D3 : hit1 ? S1 : IDLE;
      D3:      st_nx = hit1 ? D4 : IDLE;
      D4:      st_nx = hit2 ? D5 : (hit1 ? S1 : IDLE);
      D5:      st_nx = hit1 ? S1 : IDLE;
      OPEN:    st_nx = OPEN;
      default: st_nx = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE;
      gap <= '0;
    end else if (close_w) begin
      st <= IDLE;
      gap <= '0;
    end else if (ld_stb) begin
      st <= st_nx;
      gap <= '0;
    end else if (timeout) begin
      st <= IDLE;
      gap <= '0;
    end else if (mid_seq) begin
      gap <= gap + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (arm_now) cnt <= '0;
    else if (ld_stb && win_room) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q <= INIT_PROT;
      pend_off <= 1'b0;
    end else if (arm_now) begin
      prot_q <= 1'b1;
      pend_off <= 1'b0;
    end else begin
      if (prog_done && pend_off) begin
        prot_q <= 1'b0;
        pend_off <= 1'b0;
      end
      if (off_now) pend_off <= 1'b1;
    end
  end

  // R2
  open_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb && !prot_on |-> ld_pass);
  // R4
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pass && prot_on |-> st == OPEN);
  // R3
  arm_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_now && !prog_done |=> st == OPEN && prot_on);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);
  // R6
  close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_w |=> st == IDLE && prot_on);
  // R7
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> $past(prog_done));
  // R9
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap < GW'(GAP_CYC));
endmodule

// File: tb/sim_wp_cmd_detect.sv
`timescale 1ns/100ps
module sim_wp_cmd_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_stb = 1'b0;
  logic [14:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic prog_done = 1'b0;
  logic ld_pass, prot_on;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  wp_cmd_detect #(.PAGE_BYTES(4), .GAP_CYC(6)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_addr(ld_addr),
    .ld_data(ld_data), .prog_done(prog_done), .ld_pass(ld_pass),
    .prot_on(prot_on));

  typedef struct packed {
    logic stb; logic [14:0] a; logic [7:0] d; logic done;
    logic xp; logic xr; logic [3:0] req;
  } vec_t;

  localparam int N = 57;
  // tags: R1 reset, R8 broken step, R10 same-cycle completion
  localparam vec_t TBL [N] = '{
    '{0,15'h0000,8'h00,0,0,0,4'd1},
    '{1,15'h1234,8'h11,0,1,0,4'd2},
    '{1,15'h5555,8'hAA,0,1,0,4'd2},
    '{1,15'h2AAA,8'h55,0,1,0,4'd2},
    '{1,15'h5555,8'hA0,0,1,0,4'd3},
    '{1,15'h0100,8'h33,0,1,1,4'd5},
    '{1,15'h0101,8'h34,0,1,1,4'd5},
    '{1,15'h0102,8'h35,0,1,1,4'd5},
    '{1,15'h0103,8'h36,0,1,1,4'd5},
    '{1,15'h0104,8'h37,0,0,1,4'd5},
    '{0,15'h0000,8'h00,1,0,1,4'd6},
    '{1,15'h0200,8'h44,0,0,1,4'd4},
    '{1,15'h5555,8'hAA,0,0,1,4'd4},
    '{1,15'h2AAA,8'h55,0,0,1,4'd4},
    '{1,15'h5555,8'hA0,0,0,1,4'd3},
    '{1,15'h0300,8'h66,1,1,1,4'd10},
    '{1,15'h0301,8'h67,0,0,1,4'd6},
    '{1,15'h5555,8'hAA,0,0,1,4'd7},
    '{1,15'h2AAA,8'h55,0,0,1,4'd7},
    '{1,15'h5555,8'h80,0,0,1,4'd7},
    '{1,15'h5555,8'hAA,0,0,1,4'd7},
    '{1,15'h2AAA,8'h55,0,0,1,4'd7},
    '{1,15'h5555,8'h20,1,0,1,4'd10},
    '{0,15'h0000,8'h00,0,0,1,4'd7},
    '{0,15'h0000,8'h00,1,0,1,4'd7},
    '{0,15'h0000,8'h00,0,0,0,4'd7},
    '{1,15'h0400,8'h77,0,1,0,4'd2},
    '{1,15'h5555,8'hAA,0,1,0,4'd8},
    '{1,15'h2AAA,8'h56,0,1,0,4'd8},
    '{1,15'h5555,8'hA0,0,1,0,4'd8},
    '{0,15'h0000,8'h00,0,0,0,4'd8},
    '{1,15'h5555,8'hAA,0,1,0,4'd8},
    '{1,15'h5555,8'hAA,0,1,0,4'd8},
    '{1,15'h2AAA,8'h55,0,1,0,4'd8},
    '{1,15'h5555,8'hA0,0,1,0,4'd8},
    '{0,15'h0000,8'h00,0,0,1,4'd8},
    '{0,15'h0000,8'h00,1,0,1,4'd6},
    '{1,15'h5555,8'hAA,0,0,1,4'd9},
    '{1,15'h2AAA,8'h55,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{1,15'h5555,8'hA0,0,0,1,4'd9},
    '{1,15'h0500,8'h88,0,0,1,4'd9},
    '{1,15'h5555,8'hAA,0,0,1,4'd9},
    '{1,15'h2AAA,8'h55,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{0,15'h0000,8'h00,0,0,1,4'd9},
    '{1,15'h5555,8'hA0,0,0,1,4'd9},
    '{1,15'h0600,8'h99,0,1,1,4'd9},
    '{0,15'h0000,8'h00,1,0,1,4'd6}
  };

  task automatic check(input string tag, input int step, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s step %0d: actual=%0b expected=%0b", tag, step, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [14:0] a, input logic [7:0] d, input logic dn);
    @(negedge clk);
    ld_stb = s; ld_addr = a; ld_data = d; prog_done = dn;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    check("R1 prot", -1, prot_on, 1'b0);
    check("R1 pass", -1, ld_pass, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      drive(TBL[i].stb, TBL[i].a, TBL[i].d, TBL[i].done);
      check($sformatf("R%0d pass", TBL[i].req), i, ld_pass, TBL[i].xp);
      check($sformatf("R%0d prot", TBL[i].req), i, prot_on, TBL[i].xr);
    end
    // R1: reset while protected returns to the factory state
    drive(0, 15'h0, 8'h0, 0);
    check("R1 prot before reset", 100, prot_on, 1'b1);
    rst_n = 1'b0;
    drive(0, 15'h0, 8'h0, 0);
    rst_n = 1'b1;
    drive(1, 15'h0700, 8'h12, 0);
    check("R1 prot after reset", 101, prot_on, 1'b0);
    check("R1 pass after reset", 101, ld_pass, 1'b1);
    // R8: stray write in the middle of the disable path
    drive(1, 15'h5555, 8'hAA, 0);
    drive(1, 15'h2AAA, 8'h55, 0);
    drive(1, 15'h5555, 8'hA0, 0);
    drive(0, 15'h0, 8'h0, 1);
    check("R8 armed", 102, prot_on, 1'b1);
    drive(1, 15'h5555, 8'hAA, 0);
    drive(1, 15'h2AAA, 8'h55, 0);
    drive(1, 15'h5555, 8'h80, 0);
    drive(1, 15'h1111, 8'hAA, 0);
    drive(1, 15'h2AAA, 8'h55, 0);
    drive(1, 15'h5555, 8'h20, 0);
    drive(0, 15'h0, 8'h0, 1);
    drive(0, 15'h0, 8'h0, 0);
    check("R8 disable broken", 103, prot_on, 1'b1);
    drive(0, 15'h0, 8'h0, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule